// File: doc/BRIEF.md
# Multiply-Accumulate Unit with Guard Bits

This block is the arithmetic core of a signal-processing datapath. Each cycle it takes two 16-bit operands and forms their full product. It then either loads that product into a 36-bit accumulator, adds it, subtracts it, or clears the accumulator. Each operation interprets the operands as signed or unsigned and as integer or fractional. In fractional mode the product is doubled, so two 1.15 values give a 1.31 result.

The accumulator has four guard bits above a 32-bit result. Long sums can grow past the 32-bit range without wrapping. The guard bits are flagged as soon as they carry significant information. A saturating 32-bit view clamps to the largest positive or negative 32-bit value while they do. A separate write port loads all 36 bits. A sticky flag records any wrap of the full 36-bit accumulator.

The top has no state machine. Its control is a registered accumulator and a flag, updated by a decoded operation. The operations are named `MAC_MUL`, `MAC_ADD`, `MAC_SUB` and `MAC_CLR`. On each rising clock edge the accumulator takes one of four values: the write data, the selected operation's result, zero on clear, or its own value when idle.

Top module: `mac_guard_unit`

## Requirements
- R1: After an active-low reset the accumulator is zero, and `ext_used` and `ovf` are low.
- R2: The 36-bit accumulator is presented as `acc_ext` (bits 35:32), `acc_hi` (bits 31:16) and `acc_lo` (bits 15:0). When `wr_en` is high, all 36 bits take `wr_data` at the next edge, `ovf` is cleared, and any operation in the same cycle is ignored.
- R3: With `op_valid` high, `op_sel` selects the operation. 0 loads the product, 1 adds it, 2 subtracts it from the accumulator, and 3 clears the accumulator and `ovf`. Results appear one edge later.
- R4: With `is_signed` high, both operands are two's complement, and the product is sign-extended through all 36 bits.
- R5: With `is_signed` low, both operands are unsigned, and the product is zero-extended.
- R6: With `is_frac` high, the product is shifted left by one bit before it is used.
- R7: A signed fractional product of 0x8000 by 0x8000 is replaced by 0x0_7FFF_FFFF.
- R8: `ext_used` is high exactly when accumulator bits 35:31 are not all equal.
- R9: `sat_out` equals accumulator bits 31:0 while `ext_used` is low. Otherwise it is 0x7FFFFFFF when bit 35 is 0, and 0x80000000 when bit 35 is 1.
- R10: `ovf` is set when an add or subtract result leaves the 36-bit two's-complement range. It is cleared by clear, product load or write, and holds otherwise.
- R11: With neither `op_valid` nor `wr_en` high, the accumulator and `ovf` do not change.
- R12: Fifteen accumulations of the largest signed fractional product, starting from zero, do not set `ovf`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Apply `op_sel` this cycle |
| op_sel | input | 2 | 0 load, 1 add, 2 subtract, 3 clear |
| is_signed | input | 1 | Operands are two's complement |
| is_frac | input | 1 | Fractional product (left shift by one) |
| opnd_a | input | 16 | First multiplier operand |
| opnd_b | input | 16 | Second multiplier operand |
| wr_en | input | 1 | Load the accumulator from `wr_data` |
| wr_data | input | 36 | Accumulator load value |
| acc_ext | output | 4 | Guard bits 35:32 |
| acc_hi | output | 16 | Accumulator bits 31:16 |
| acc_lo | output | 16 | Accumulator bits 15:0 |
| ext_used | output | 1 | Guard bits hold significant data |
| sat_out | output | 32 | Saturated 32-bit view |
| ovf | output | 1 | Sticky 36-bit wrap flag |

## Verification
Some properties are checked on every cycle:
- the saturated view's clamping and pass-through;
- write loading and its priority over operations;
- the clear result;
- hold when idle;
- stickiness of the wrap flag;
- the signed-integer product load.

Unsigned and fractional product values, the -1.0 by -1.0 replacement, sign extension into the guard bits, and the fifteen-step headroom are shown only by the bench's scenarios. There, a behavioural model tracks the accumulator through a mixed table of operations and modes.

// File: rtl/mac_pkg.sv
package mac_pkg;
    localparam int MAC_OPW  = 16;
    localparam int MAC_ACCW = 36;

    typedef enum logic [1:0] {
        MAC_MUL = 2'd0,
        MAC_ADD = 2'd1,
        MAC_SUB = 2'd2,
        MAC_CLR = 2'd3
    } mac_op_e;
endpackage

// File: rtl/mac_product.sv
// Full product of two operands, sign or zero extended to the accumulator width,
// with optional fractional doubling and the -1.0 * -1.0 substitution.
module mac_product #(
    parameter int OPW  = 16,
    parameter int ACCW = 36
) (
    input  logic            is_signed,
    input  logic            is_frac,
    input  logic [OPW-1:0]  opnd_a,
    input  logic [OPW-1:0]  opnd_b,
    output logic [ACCW-1:0] prod
);
    localparam int RAWW = 2 * OPW + 2;
    localparam int PADW = ACCW - RAWW;
    localparam logic [OPW-1:0] MOST_NEG = {1'b1, {(OPW-1){1'b0}}};
    localparam logic [ACCW-1:0] FRAC_MAX = {{(ACCW-2*OPW+1){1'b0}}, {(2*OPW-1){1'b1}}};

    logic signed [OPW:0]    a_x, b_x;
    logic signed [RAWW-1:0] raw;
    logic [ACCW-1:0]        raw_x;
    logic                   neg_one_sq;

    always_comb begin
        a_x        = {is_signed & opnd_a[OPW-1], opnd_a};
        b_x        = {is_signed & opnd_b[OPW-1], opnd_b};
        raw        = a_x * b_x;
        raw_x      = {{PADW{raw[RAWW-1]}}, raw};
        neg_one_sq = is_signed && is_frac && (opnd_a == MOST_NEG) && (opnd_b == MOST_NEG);
        if (neg_one_sq)
            prod = FRAC_MAX;
        else if (is_frac)
            prod = {raw_x[ACCW-2:0], 1'b0};
        else
            prod = raw_x;
    end
endmodule

// File: rtl/mac_accum.sv
// Accumulator register with load, add, subtract, clear and sticky wrap flag.
module mac_accum
    import mac_pkg::*;
#(
    parameter int ACCW = 36
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_valid,
    input  mac_op_e         op,
    input  logic [ACCW-1:0] prod,
    input  logic            wr_en,
    input  logic [ACCW-1:0] wr_data,
    output logic [ACCW-1:0] acc,
    output logic            ovf
);
    localparam int MSB = ACCW - 1;

    logic [ACCW-1:0] acc_q, acc_d, sum, diff;
    logic            ovf_q, ovf_d;

    always_comb begin
        sum   = acc_q + prod;
        diff  = acc_q - prod;
        acc_d = acc_q;
        ovf_d = ovf_q;
        if (wr_en) begin
            acc_d = wr_data;
            ovf_d = 1'b0;
        end else if (op_valid) begin
            unique case (op)
                MAC_MUL: begin
                    acc_d = prod;
                    ovf_d = 1'b0;
                end
                MAC_ADD: begin
                    acc_d = sum;
                    if (acc_q[MSB] == prod[MSB] && sum[MSB] != acc_q[MSB])
                        ovf_d = 1'b1;
                end
                MAC_SUB: begin
                    acc_d = diff;
                    if (acc_q[MSB] != prod[MSB] && diff[MSB] != acc_q[MSB])
                        ovf_d = 1'b1;
                end
                MAC_CLR: begin
                    acc_d = '0;
                    ovf_d = 1'b0;
                end
                default: begin
                    acc_d = acc_q;
                    ovf_d = ovf_q;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            acc_q <= acc_d;
            ovf_q <= ovf_d;
        end
    end

    assign acc = acc_q;
    assign ovf = ovf_q;
endmodule

// File: rtl/mac_readout.sv
// Guard-bit detection and saturating 32-bit view of the accumulator.
module mac_readout #(
    parameter int OPW  = 16,
    parameter int ACCW = 36
) (
    input  logic [ACCW-1:0]  acc,
    output logic             ext_used,
    output logic [2*OPW-1:0] sat_out
);
    localparam int RESW = 2 * OPW;
    localparam logic [RESW-1:0] POS_LIM = {1'b0, {(RESW-1){1'b1}}};
    localparam logic [RESW-1:0] NEG_LIM = {1'b1, {(RESW-1){1'b0}}};

    logic [ACCW-RESW:0] top_bits;

    always_comb begin
        top_bits = acc[ACCW-1:RESW-1];
        ext_used = !((&top_bits) || !(|top_bits));
        if (!ext_used)
            sat_out = acc[RESW-1:0];
        else if (acc[ACCW-1])
            sat_out = NEG_LIM;
        else
            sat_out = POS_LIM;
    end
endmodule

// File: rtl/mac_guard_unit.sv
module mac_guard_unit
    import mac_pkg::*;
#(
    parameter int OPW  = MAC_OPW,
    parameter int ACCW = MAC_ACCW
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  op_valid,
    input  logic [1:0]            op_sel,
    input  logic                  is_signed,
    input  logic                  is_frac,
    input  logic [OPW-1:0]        opnd_a,
    input  logic [OPW-1:0]        opnd_b,
    input  logic                  wr_en,
    input  logic [ACCW-1:0]       wr_data,
    output logic [ACCW-2*OPW-1:0] acc_ext,
    output logic [OPW-1:0]        acc_hi,
    output logic [OPW-1:0]        acc_lo,
    output logic                  ext_used,
    output logic [2*OPW-1:0]      sat_out,
    output logic                  ovf
);
    logic [ACCW-1:0] prod;
    logic [ACCW-1:0] acc;
    mac_op_e         op;

    assign op = mac_op_e'(op_sel);

    mac_product #(.OPW(OPW), .ACCW(ACCW)) u_prod (
        .is_signed (is_signed),
        .is_frac   (is_frac),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .prod      (prod)
    );

    mac_accum #(.ACCW(ACCW)) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_valid (op_valid),
        .op       (op),
        .prod     (prod),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .acc      (acc),
        .ovf      (ovf)
    );

    mac_readout #(.OPW(OPW), .ACCW(ACCW)) u_rd (
        .acc      (acc),
        .ext_used (ext_used),
        .sat_out  (sat_out)
    );

    assign acc_ext = acc[ACCW-1:2*OPW];
    assign acc_hi  = acc[2*OPW-1:OPW];
    assign acc_lo  = acc[OPW-1:0];
endmodule

// File: rtl/mac_guard_chk.sv
module mac_guard_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        op_valid,
    input logic [1:0]  op_sel,
    input logic        is_signed,
    input logic        is_frac,
    input logic [15:0] opnd_a,
    input logic [15:0] opnd_b,
    input logic        wr_en,
    input logic [35:0] wr_data,
    input logic [3:0]  acc_ext,
    input logic [15:0] acc_hi,
    input logic [15:0] acc_lo,
    input logic        ext_used,
    input logic [31:0] sat_out,
    input logic        ovf
);
    logic [35:0]        acc_all;
    logic signed [35:0] sint_ref;

    assign acc_all  = {acc_ext, acc_hi, acc_lo};
    assign sint_ref = 36'($signed(opnd_a)) * 36'($signed(opnd_b));

    p_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (acc_all == $past(wr_data)) && !ovf);

    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == 2'd3 && !wr_en) |=> (acc_all == 36'd0) && !ovf);

    p_signed_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == 2'd0 && is_signed && !is_frac && !wr_en)
        |=> acc_all == $past(sint_ref));

    p_quiet_ext_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_ext == 4'h0 && !acc_hi[15]) |-> !ext_used);

    p_sat_clamp_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ext_used |-> sat_out == (acc_ext[3] ? 32'h8000_0000 : 32'h7FFF_FFFF));

    p_sat_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_used |-> sat_out == {acc_hi, acc_lo});

    p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !wr_en && !(op_valid && (op_sel == 2'd3 || op_sel == 2'd0))) |=> ovf);

    p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid && !wr_en) |=> $stable(acc_all) && $stable(ovf));
endmodule

bind mac_guard_unit mac_guard_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_sel    (op_sel),
    .is_signed (is_signed),
    .is_frac   (is_frac),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .acc_ext   (acc_ext),
    .acc_hi    (acc_hi),
    .acc_lo    (acc_lo),
    .ext_used  (ext_used),
    .sat_out   (sat_out),
    .ovf       (ovf)
);

// File: tb/sim_mac_guard_unit.sv
`timescale 1ns/1ps
module sim_mac_guard_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [1:0]  op_sel = 2'd0;
    logic        is_signed = 1'b0;
    logic        is_frac = 1'b0;
    logic [15:0] opnd_a = '0;
    logic [15:0] opnd_b = '0;
    logic        wr_en = 1'b0;
    logic [35:0] wr_data = '0;
    logic [3:0]  acc_ext;
    logic [15:0] acc_hi;
    logic [15:0] acc_lo;
    logic        ext_used;
    logic [31:0] sat_out;
    logic        ovf;

    int n_chk = 0;
    int n_bad = 0;

    logic [35:0] m_acc = '0;
    logic        m_ovf = 1'b0;

    always #2.5 clk = ~clk;

    mac_guard_unit u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
        .is_signed(is_signed), .is_frac(is_frac), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .wr_en(wr_en), .wr_data(wr_data), .acc_ext(acc_ext), .acc_hi(acc_hi),
        .acc_lo(acc_lo), .ext_used(ext_used), .sat_out(sat_out), .ovf(ovf)
    );

    // {op[1:0], signed, frac, a[15:0], b[15:0]}
    localparam logic [35:0] VEC [16] = '{
        {2'd3, 1'b1, 1'b0, 16'h0000, 16'h0000},
        {2'd0, 1'b1, 1'b0, 16'h1234, 16'h5678},
        {2'd1, 1'b1, 1'b0, 16'h8000, 16'h8000},
        {2'd1, 1'b1, 1'b0, 16'h7FFF, 16'h8000},
        {2'd2, 1'b1, 1'b0, 16'hFFFF, 16'h0003},
        {2'd1, 1'b0, 1'b0, 16'hFFFF, 16'hFFFF},
        {2'd2, 1'b0, 1'b0, 16'h8000, 16'h0002},
        {2'd0, 1'b1, 1'b1, 16'h8000, 16'h8000},
        {2'd1, 1'b1, 1'b1, 16'h8000, 16'h7FFF},
        {2'd2, 1'b1, 1'b1, 16'hC000, 16'h4000},
        {2'd1, 1'b0, 1'b1, 16'hFFFF, 16'hFFFF},
        {2'd0, 1'b0, 1'b1, 16'h1234, 16'h8001},
        {2'd1, 1'b1, 1'b0, 16'h8000, 16'h8000},
        {2'd2, 1'b1, 1'b1, 16'h8000, 16'h8000},
        {2'd1, 1'b1, 1'b1, 16'h7FFF, 16'h7FFF},
        {2'd3, 1'b0, 1'b0, 16'h0000, 16'h0000}
    };

    localparam longint LIM_HI36 = 64'sd34359738367;
    localparam longint LIM_LO36 = -64'sd34359738368;

    function automatic longint sx36(input logic [35:0] v);
        return $signed({{28{v[35]}}, v});
    endfunction

    function automatic logic exp_ext(input logic [35:0] v);
        longint s = sx36(v);
        return (s > 64'sd2147483647) || (s < -64'sd2147483648);
    endfunction

    function automatic logic [31:0] exp_sat(input logic [35:0] v);
        if (!exp_ext(v)) return v[31:0];
        return (sx36(v) < 0) ? 32'h8000_0000 : 32'h7FFF_FFFF;
    endfunction

    function automatic logic [35:0] ref_prod(input logic s, input logic f,
                                             input logic [15:0] a, input logic [15:0] b);
        longint x = s ? longint'($signed(a)) : longint'({48'd0, a});
        longint y = s ? longint'($signed(b)) : longint'({48'd0, b});
        longint r = x * y;
        if (f) begin
            if (s && a == 16'h8000 && b == 16'h8000) r = 64'sd2147483647;
            else r = r * 2;
        end
        return r[35:0];
    endfunction

    task automatic model_step(input logic [1:0] op, input logic s, input logic f,
                              input logic [15:0] a, input logic [15:0] b);
        logic [35:0] p = ref_prod(s, f, a, b);
        longint t;
        case (op)
            2'd0: begin m_acc = p; m_ovf = 1'b0; end
            2'd1: begin
                t = sx36(m_acc) + sx36(p);
                if (t > LIM_HI36 || t < LIM_LO36) m_ovf = 1'b1;
                m_acc = t[35:0];
            end
            2'd2: begin
                t = sx36(m_acc) - sx36(p);
                if (t > LIM_HI36 || t < LIM_LO36) m_ovf = 1'b1;
                m_acc = t[35:0];
            end
            default: begin m_acc = '0; m_ovf = 1'b0; end
        endcase
    endtask

    task automatic cycle(input logic v, input logic [1:0] op, input logic s, input logic f,
                         input logic [15:0] a, input logic [15:0] b,
                         input logic w, input logic [35:0] wd);
        op_valid = v; op_sel = op; is_signed = s; is_frac = f;
        opnd_a = a; opnd_b = b; wr_en = w; wr_data = wd;
        @(posedge clk);
        @(negedge clk);
        op_valid = 1'b0; wr_en = 1'b0;
    endtask

    task automatic check(input string tag, input logic [35:0] e_acc, input logic e_ovf);
        logic [35:0] got = {acc_ext, acc_hi, acc_lo};
        n_chk++;
        if (got !== e_acc || ovf !== e_ovf || ext_used !== exp_ext(e_acc)
            || sat_out !== exp_sat(e_acc)) begin
            n_bad++;
            $display("FAIL %s: acc=%09h ovf=%0b ext=%0b sat=%08h expected acc=%09h ovf=%0b ext=%0b sat=%08h",
                     tag, got, ovf, ext_used, sat_out, e_acc, e_ovf, exp_ext(e_acc), exp_sat(e_acc));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run hung, actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset state", 36'h0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: R3 R4 R5 R6 R7 R8 R9 R10 against the behavioural model
        foreach (VEC[i]) begin
            cycle(1'b1, VEC[i][35:34], VEC[i][33], VEC[i][32], VEC[i][31:16], VEC[i][15:0], 1'b0, '0);
            model_step(VEC[i][35:34], VEC[i][33], VEC[i][32], VEC[i][31:16], VEC[i][15:0]);
            check($sformatf("R3 table vector %0d", i), m_acc, m_ovf);
        end

        // R2 write layout and priority over a clear in the same cycle
        cycle(1'b1, 2'd3, 1'b0, 1'b0, 16'h0, 16'h0, 1'b1, 36'hA_1234_5678);
        check("R2 write wins", 36'hA_1234_5678, 1'b0);
        if (acc_ext !== 4'hA || acc_hi !== 16'h1234 || acc_lo !== 16'h5678) begin
            n_bad++;
            $display("FAIL R2 field split: %h %h %h expected a 1234 5678", acc_ext, acc_hi, acc_lo);
        end
        n_chk++;

        // R11 idle hold
        cycle(1'b0, 2'd3, 1'b1, 1'b1, 16'hFFFF, 16'hFFFF, 1'b0, 36'h0);
        check("R11 idle hold", 36'hA_1234_5678, 1'b0);

        // R4 signed integer load: -1 * 2
        cycle(1'b1, 2'd0, 1'b1, 1'b0, 16'hFFFF, 16'h0002, 1'b0, '0);
        check("R4 signed product", 36'hF_FFFF_FFFE, 1'b0);

        // R5 unsigned integer load
        cycle(1'b1, 2'd0, 1'b0, 1'b0, 16'hFFFF, 16'hFFFF, 1'b0, '0);
        check("R5 unsigned product, R9 clamp", 36'h0_FFFE_0001, 1'b0);

        // R6 fractional 0.5 * 0.5
        cycle(1'b1, 2'd0, 1'b1, 1'b1, 16'h4000, 16'h4000, 1'b0, '0);
        check("R6 fractional shift", 36'h0_2000_0000, 1'b0);

        // R7 -1.0 * -1.0
        cycle(1'b1, 2'd0, 1'b1, 1'b1, 16'h8000, 16'h8000, 1'b0, '0);
        check("R7 neg-one squared", 36'h0_7FFF_FFFF, 1'b0);

        // R12 headroom: fifteen worst-case adds from zero
        cycle(1'b1, 2'd3, 1'b0, 1'b0, 16'h0, 16'h0, 1'b0, '0);
        for (int k = 0; k < 15; k++)
            cycle(1'b1, 2'd1, 1'b1, 1'b1, 16'h8000, 16'h8000, 1'b0, '0);
        check("R12 fifteen accumulations, R8 guard in use", 36'h7_7FFF_FFF1, 1'b0);

        // R10 add wrap, sticky through idle and a harmless add, cleared by clear
        cycle(1'b0, 2'd0, 1'b0, 1'b0, 16'h0, 16'h0, 1'b1, 36'h7_FFFF_FFFF);
        cycle(1'b1, 2'd1, 1'b1, 1'b0, 16'h0001, 16'h0001, 1'b0, '0);
        check("R10 add wrap", 36'h8_0000_0000, 1'b1);
        cycle(1'b0, 2'd0, 1'b0, 1'b0, 16'h0, 16'h0, 1'b0, '0);
        cycle(1'b1, 2'd1, 1'b1, 1'b0, 16'h0000, 16'h0000, 1'b0, '0);
        check("R10 flag sticky", 36'h8_0000_0000, 1'b1);
        cycle(1'b1, 2'd3, 1'b0, 1'b0, 16'h0, 16'h0, 1'b0, '0);
        check("R10 clear resets flag", 36'h0, 1'b0);

        // R10 subtract wrap, then product load clears the flag
        cycle(1'b0, 2'd0, 1'b0, 1'b0, 16'h0, 16'h0, 1'b1, 36'h8_0000_0000);
        cycle(1'b1, 2'd2, 1'b1, 1'b0, 16'h0001, 16'h0001, 1'b0, '0);
        check("R10 subtract wrap", 36'h7_FFFF_FFFF, 1'b1);
        cycle(1'b1, 2'd0, 1'b0, 1'b0, 16'h0003, 16'h0005, 1'b0, '0);
        check("R10 load clears flag", 36'h0_0000_000F, 1'b0);

        // R1 reset from a non-zero state
        cycle(1'b0, 2'd0, 1'b0, 1'b0, 16'h0, 16'h0, 1'b1, 36'h9_0000_0001);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R1 reset clears", 36'h0, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule